// File: doc/BRIEF.md
# Tracking Filter Capacitor Code Interpolator

This block turns a set of per-part calibration bytes and a tuned channel frequency into the two switched-capacitor codes of an RF tracking filter. One code is 8 bits wide and sets the series capacitor array. The other is 6 bits wide and sets the parallel array. Each code follows a straight line in frequency. The line has an intercept byte and a slope byte. Both bytes are read as unsigned fractions of 256, and the slope byte has one subtracted from it. A band-select input picks the low-band (VHF) or high-band (UHF) set of four bytes.

The host supplies the frequency in whole MHz. It then pulses `start` and waits for `done`. Inside, a shift-add multiplier and a restoring divider run one after the other, first for the series code and then for the parallel code. Every step is exact integer arithmetic, so the result is the true floor of the real-valued formula. For a field of width W, a given frequency scale s, and offset c, the code is

code = floor( 2^W × ( I/256 + (S/256 − 1) × s × f ) ) − c

The result is then clamped to the range 0 … 2^W−1. Since s is a multiple of 1/200, the block evaluates this as floor(2^W × (200·I + (S−256)·k·f) / 51200).

Top module: `tfi_interp`

## Requirements
- R1: A `start` pulse while `busy` is low sets `busy` on the next cycle. `busy` then stays high until the cycle in which `done` is high, and in that cycle `busy` is low.
- R2: `done` is high for exactly one cycle. `series_code` and `par_code` change only in a cycle where `done` is high, and they hold their value afterwards.
- R3: A `start` pulse while `busy` is high is ignored. The codes that follow belong to the request that was accepted, even if the inputs change while the block is busy.
- R4: With `band_uhf`=0, `series_code` = floor((200·I + (S−256)·3·f)/200) using the low-band series bytes. This is a frequency scale of 1.5e-2 on an 8-bit field.
- R5: With `band_uhf`=0, `par_code` = floor((200·I + (S−256)·2·f)/800) using the low-band parallel bytes. This is a frequency scale of 1e-2 on a 6-bit field.
- R6: With `band_uhf`=1, both codes use the high-band bytes with k=1 (a scale of 5e-3). The parallel code is floor((200·I + (S−256)·f)/800).
- R7: With `band_uhf`=1, `series_code` = floor((200·I + (S−256)·f)/200) − 10.
- R8: A result below 0 gives code 0. This covers a negative numerator and an offset larger than the quotient. A result above 255 (series) or 63 (parallel) is clamped to that maximum.
- R9: After reset, `busy`=0, `done`=0, `series_code`=0 and `par_code`=0.
- R10: `done` arrives no more than 64 cycles after the cycle that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; sampled only while idle |
| band_uhf | input | 1 | 0 selects the low-band byte set, 1 the high-band set |
| freq_mhz | input | 10 | Channel frequency in MHz, unsigned |
| vhf_ser_icpt | input | 8 | Low-band series intercept byte |
| vhf_ser_slope | input | 8 | Low-band series slope byte |
| vhf_par_icpt | input | 8 | Low-band parallel intercept byte |
| vhf_par_slope | input | 8 | Low-band parallel slope byte |
| uhf_ser_icpt | input | 8 | High-band series intercept byte |
| uhf_ser_slope | input | 8 | High-band series slope byte |
| uhf_par_icpt | input | 8 | High-band parallel intercept byte |
| uhf_par_slope | input | 8 | High-band parallel slope byte |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when new codes are valid |
| series_code | output | 8 | Series capacitor code |
| par_code | output | 6 | Parallel capacitor code |

## Verification
Random byte sets are drawn across the three valid frequency ranges. With slope bytes near 256 the frequency term is small, so these cases check the intercept path and the per-field divisor. With slope bytes near 0 the numerator goes negative, which exercises the zero clamp. Directed cases set the high-band series quotient just below, at, and just above the offset of 10, which separates a correct subtract-then-clamp from a wrap. Other directed cases use frequency 0 with a full-scale intercept to reach the field maxima, and change the inputs in the middle of a computation to show that a second `start` cannot disturb the request already accepted.

// File: rtl/tfi_pkg.sv
package tfi_pkg;
  localparam int BYTE_W   = 8;
  localparam int SER_W    = 8;
  localparam int PAR_W    = 6;
  localparam int FREQ_DIV = 200;              // frequency scales are k/FREQ_DIV
  localparam int K_W      = 2;
  localparam int ICPT_W   = 16;               // holds FREQ_DIV * 255
  localparam int DEN_W    = 10;               // holds 256*FREQ_DIV >> PAR_W
  localparam int UHF_SER_OFFSET = 10;
  localparam int OFF_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_MUL, ST_DIV, ST_STORE
  } tfi_state_t;

  // slope multiplier in units of 1/FREQ_DIV
  function automatic logic [K_W-1:0] slope_k(input logic uhf, input logic par);
    if (uhf)      return K_W'(1);
    else if (par) return K_W'(2);
    else          return K_W'(3);
  endfunction

  // 2^W / (256*FREQ_DIV) folded into a single divisor
  function automatic logic [DEN_W-1:0] divisor_of(input logic par);
    if (par) return DEN_W'((256 * FREQ_DIV) >> PAR_W);
    else     return DEN_W'((256 * FREQ_DIV) >> SER_W);
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic uhf, input logic par);
    return (uhf && !par) ? OFF_W'(UHF_SER_OFFSET) : OFF_W'(0);
  endfunction

  // subtract offset, clamp to [0, field max]
  function automatic logic [SER_W-1:0] finish_code(input logic [ICPT_W-1:0] q,
                                                   input logic [OFF_W-1:0]  off,
                                                   input logic              par);
    logic [ICPT_W-1:0] diff;
    logic [ICPT_W-1:0] maxv;
    maxv = par ? ICPT_W'((1 << PAR_W) - 1) : ICPT_W'((1 << SER_W) - 1);
    if (q < ICPT_W'(off)) return '0;
    diff = q - ICPT_W'(off);
    if (diff > maxv) return SER_W'(maxv);
    return SER_W'(diff);
  endfunction
endpackage

// File: rtl/tfi_coef_mux.sv
module tfi_coef_mux
  import tfi_pkg::*;
(
  input  logic                      uhf,
  input  logic                      par,
  input  logic [3:0][BYTE_W-1:0]    icpt_set,   // [0]=vhf ser,[1]=vhf par,[2]=uhf ser,[3]=uhf par
  input  logic [3:0][BYTE_W-1:0]    slope_set,
  output logic [BYTE_W-1:0]         icpt,
  output logic [BYTE_W-1:0]         slope
);
  logic [1:0] idx;
  assign idx   = {uhf, par};
  assign icpt  = icpt_set[idx];
  assign slope = slope_set[idx];
endmodule

// File: rtl/tfi_shift_mul.sv
module tfi_shift_mul #(
  parameter int A_W = 10,
  parameter int B_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] prod,
  output logic               rdy
);
  localparam int P_W  = A_W + B_W;
  localparam int CNT_W = $clog2(B_W + 1);

  logic [P_W-1:0]   mcand;
  logic [B_W-1:0]   mplier;
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0; mcand <= '0; mplier <= '0; cnt <= '0; run <= 1'b0; rdy <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        prod   <= '0;
        mcand  <= P_W'(a);
        mplier <= b;
        cnt    <= CNT_W'(B_W);
        run    <= 1'b1;
      end else if (run) begin
        if (mplier[0]) prod <= prod + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          rdy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tfi_restoring_div.sv
module tfi_restoring_div #(
  parameter int N_W = 16,
  parameter int D_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quo,
  output logic           rdy
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [D_W-1:0]   rem;
  logic [D_W-1:0]   dvs;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [D_W:0]     shifted;
  logic             fits;

  assign shifted = {rem, quo[N_W-1]};
  assign fits    = shifted >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; dvs <= '0; quo <= '0; cnt <= '0; run <= 1'b0; rdy <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        rem <= '0;
        dvs <= divisor;
        quo <= dividend;
        cnt <= CNT_W'(N_W);
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? D_W'(shifted - {1'b0, dvs}) : D_W'(shifted);
        quo <= {quo[N_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          rdy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tfi_interp.sv
module tfi_interp
  import tfi_pkg::*;
#(
  parameter int FREQ_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              band_uhf,
  input  logic [FREQ_W-1:0] freq_mhz,
  input  logic [7:0]        vhf_ser_icpt,
  input  logic [7:0]        vhf_ser_slope,
  input  logic [7:0]        vhf_par_icpt,
  input  logic [7:0]        vhf_par_slope,
  input  logic [7:0]        uhf_ser_icpt,
  input  logic [7:0]        uhf_ser_slope,
  input  logic [7:0]        uhf_par_icpt,
  input  logic [7:0]        uhf_par_slope,
  output logic              busy,
  output logic              done,
  output logic [7:0]        series_code,
  output logic [5:0]        par_code
);
  localparam int MA_W = BYTE_W + K_W;         // |slope-256| * k
  localparam int P_W  = MA_W + FREQ_W;

  tfi_state_t              state;
  logic                    uhf_q;
  logic                    sel_par;
  logic [FREQ_W-1:0]       freq_q;
  logic [3:0][BYTE_W-1:0]  icpt_q, slope_q;
  logic [ICPT_W-1:0]       q_reg;
  logic [SER_W-1:0]        ser_tmp;

  logic [BYTE_W-1:0]       icpt_cur, slope_cur;
  logic [BYTE_W:0]         slope_mag;
  logic [MA_W-1:0]         mul_a;
  logic [ICPT_W-1:0]       icpt_scaled;
  logic                    mul_go, mul_rdy, div_go, div_rdy, num_neg;
  logic [P_W-1:0]          prod;
  logic [ICPT_W-1:0]       quo;

  // named events for the checker
  logic                    stage_fire;
  logic [ICPT_W-1:0]       stage_q;
  logic [OFF_W-1:0]        stage_off;
  logic [SER_W-1:0]        stage_code;

  tfi_coef_mux u_mux (
    .uhf       (uhf_q),
    .par       (sel_par),
    .icpt_set  (icpt_q),
    .slope_set (slope_q),
    .icpt      (icpt_cur),
    .slope     (slope_cur)
  );

  assign slope_mag   = (BYTE_W+1)'(256) - {1'b0, slope_cur};
  assign mul_a       = MA_W'({1'b0, slope_mag} * MA_W'(slope_k(uhf_q, sel_par)));
  assign icpt_scaled = ICPT_W'(icpt_cur) * ICPT_W'(FREQ_DIV);
  assign num_neg     = prod > P_W'(icpt_scaled);
  assign mul_go      = (state == ST_PREP);
  assign div_go      = (state == ST_MUL) && mul_rdy && !num_neg;

  tfi_shift_mul #(.A_W(MA_W), .B_W(FREQ_W)) u_mul (
    .clk (clk), .rst_n (rst_n), .go (mul_go),
    .a (mul_a), .b (freq_q), .prod (prod), .rdy (mul_rdy)
  );

  tfi_restoring_div #(.N_W(ICPT_W), .D_W(DEN_W)) u_div (
    .clk (clk), .rst_n (rst_n), .go (div_go),
    .dividend (icpt_scaled - prod[ICPT_W-1:0]),
    .divisor  (divisor_of(sel_par)),
    .quo (quo), .rdy (div_rdy)
  );

  assign stage_fire = (state == ST_STORE);
  assign stage_q    = q_reg;
  assign stage_off  = offset_of(uhf_q, sel_par);
  assign stage_code = finish_code(q_reg, stage_off, sel_par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; uhf_q <= 1'b0; sel_par <= 1'b0; freq_q <= '0;
      icpt_q <= '0; slope_q <= '0; q_reg <= '0; ser_tmp <= '0;
      busy <= 1'b0; done <= 1'b0; series_code <= '0; par_code <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          uhf_q   <= band_uhf;
          freq_q  <= freq_mhz;
          icpt_q  <= {uhf_par_icpt, uhf_ser_icpt, vhf_par_icpt, vhf_ser_icpt};
          slope_q <= {uhf_par_slope, uhf_ser_slope, vhf_par_slope, vhf_ser_slope};
          sel_par <= 1'b0;
          busy    <= 1'b1;
          state   <= ST_PREP;
        end
        ST_PREP: state <= ST_MUL;
        ST_MUL: if (mul_rdy) begin
          if (num_neg) begin
            q_reg <= '0;
            state <= ST_STORE;
          end else begin
            state <= ST_DIV;
          end
        end
        ST_DIV: if (div_rdy) begin
          q_reg <= quo;
          state <= ST_STORE;
        end
        ST_STORE: begin
          if (!sel_par) begin
            ser_tmp <= stage_code;
            sel_par <= 1'b1;
            state   <= ST_PREP;
          end else begin
            series_code <= ser_tmp;
            par_code    <= stage_code[PAR_W-1:0];
            done        <= 1'b1;
            busy        <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tfi_interp_chk.sv
module tfi_interp_chk
  import tfi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [7:0]        series_code,
  input logic [5:0]        par_code,
  input logic              stage_fire,
  input logic [ICPT_W-1:0] stage_q,
  input logic [OFF_W-1:0]  stage_off,
  input logic [SER_W-1:0]  stage_code
);
  logic [6:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (busy && !done)    lat_cnt <= lat_cnt + 7'd1;
    else                       lat_cnt <= '0;
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_busy_until_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_codes_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(series_code) && $stable(par_code)));

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);

  assert_floor_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_fire && (stage_q < ICPT_W'(stage_off))) |-> (stage_code == '0));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_cnt < 7'd64));
endmodule

bind tfi_interp tfi_interp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .series_code (series_code),
  .par_code    (par_code),
  .stage_fire  (stage_fire),
  .stage_q     (stage_q),
  .stage_off   (stage_off),
  .stage_code  (stage_code)
);

// File: tb/tfi_interp_test.sv
module tfi_interp_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       band_uhf = 1'b0;
  logic [9:0] freq_mhz = '0;
  logic [7:0] vsi = 0, vss = 0, vpi = 0, vps = 0, usi = 0, uss = 0, upi = 0, ups = 0;
  logic       busy, done;
  logic [7:0] series_code;
  logic [5:0] par_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tfi_interp uut (
    .clk (clk), .rst_n (rst_n), .start (start), .band_uhf (band_uhf), .freq_mhz (freq_mhz),
    .vhf_ser_icpt (vsi), .vhf_ser_slope (vss), .vhf_par_icpt (vpi), .vhf_par_slope (vps),
    .uhf_ser_icpt (usi), .uhf_ser_slope (uss), .uhf_par_icpt (upi), .uhf_par_slope (ups),
    .busy (busy), .done (done), .series_code (series_code), .par_code (par_code)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // code = floor(2^w * (I/256 + (S/256-1)*k*f/200)) - off, clamped
  function automatic int ref_code(int i, int s, int f, int k, int w, int off);
    longint num, q;
    int r;
    num = 64'(200 * i) + 64'((s - 256) * k * f);
    if (num < 0) return 0;
    q = (num * (64'd1 << w)) / 64'd51200;
    r = int'(q) - off;
    if (r < 0) r = 0;
    if (r > (1 << w) - 1) r = (1 << w) - 1;
    return r;
  endfunction

  task automatic run_case(input bit uhf, input int f, input int mid_f, input bit poke);
    int exp_s, exp_p, cyc, busy_bad;
    exp_s = uhf ? ref_code(usi, uss, f, 1, 8, 10) : ref_code(vsi, vss, f, 3, 8, 0);
    exp_p = uhf ? ref_code(upi, ups, f, 1, 6, 0)  : ref_code(vpi, vps, f, 2, 6, 0);
    @(negedge clk);
    band_uhf = uhf; freq_mhz = 10'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", int'(busy), 1);
    cyc = 1; busy_bad = 0;
    while (!done && cyc < 200) begin
      if (poke && cyc == 5) begin   // R3: second request and new inputs mid-run
        start = 1'b1; freq_mhz = 10'(mid_f); band_uhf = ~uhf;
        vsi = ~vsi; usi = ~usi; vpi = ~vpi; upi = ~upi;
      end else start = 1'b0;
      if (!busy) busy_bad++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R1 busy held until done", busy_bad, 0);
    check("R10 latency within 64", int'(cyc <= 64), 1);
    check("R1 busy low with done", int'(busy), 0);
    check(uhf ? "R7 uhf series code" : "R4 vhf series code", int'(series_code), exp_s);
    check(uhf ? "R6 uhf parallel code" : "R5 vhf parallel code", int'(par_code), exp_p);
    @(negedge clk);
    check("R2 done one cycle", int'(done), 0);
    check("R2 series code held", int'(series_code), exp_s);
    check("R2 parallel code held", int'(par_code), exp_p);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy reset", int'(busy), 0);
    check("R9 done reset", int'(done), 0);
    check("R9 series reset", int'(series_code), 0);
    check("R9 parallel reset", int'(par_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", int'(busy), 0);

    // R4/R5 directed: 40000-19200 -> 104 ; 40000-12800 -> 34
    vsi = 200; vss = 128; vpi = 200; vps = 128;
    run_case(1'b0, 50, 0, 1'b0);
    check("R4 directed value", int'(series_code), 104);
    check("R5 directed value", int'(par_code), 34);

    // R8 upper clamp reachable: f=0, full intercept -> 255 and 63
    vsi = 255; vss = 0; vpi = 255; vps = 0;
    run_case(1'b0, 0, 0, 1'b0);
    check("R8 series max", int'(series_code), 255);
    check("R8 parallel max", int'(par_code), 63);

    // R8 negative numerator -> 0
    vsi = 10; vss = 0; vpi = 10; vps = 0;
    run_case(1'b0, 230, 0, 1'b0);
    check("R8 series zero clamp", int'(series_code), 0);

    // R7 offset edges: quotient 9,10,11 (slope 255, f=0 removes freq term)
    uss = 255; upi = 100; ups = 255;
    usi = 9;  run_case(1'b1, 0, 0, 1'b0); check("R7 quotient 9 -> 0", int'(series_code), 0);
    usi = 10; run_case(1'b1, 0, 0, 1'b0); check("R7 quotient 10 -> 0", int'(series_code), 0);
    usi = 11; run_case(1'b1, 0, 0, 1'b0); check("R7 quotient 11 -> 1", int'(series_code), 1);

    // R3 second start and input change while busy
    vsi = 180; vss = 240; vpi = 150; vps = 250; usi = 90; uss = 200; upi = 60; ups = 220;
    run_case(1'b0, 200, 800, 1'b1);

    // R6 directed high band
    usi = 230; uss = 250; upi = 240; ups = 230;
    run_case(1'b1, 862, 0, 1'b0);

    // random mix
    for (int n = 0; n < 200; n++) begin
      int pick, f;
      bit uhf;
      pick = int'($urandom_range(0, 2));
      uhf = (pick == 2);
      if (pick == 0)      f = int'($urandom_range(47, 68));
      else if (pick == 1) f = int'($urandom_range(174, 230));
      else                f = int'($urandom_range(470, 862));
      vsi = 8'($urandom); vss = 8'($urandom_range(180, 255));
      vpi = 8'($urandom); vps = 8'($urandom_range(180, 255));
      usi = 8'($urandom); uss = 8'($urandom_range(150, 255));
      upi = 8'($urandom); ups = 8'($urandom_range(150, 255));
      if (n % 10 == 0) begin vss = 8'($urandom); uss = 8'($urandom); end
      run_case(uhf, f, int'($urandom_range(0, 1023)), (n % 7 == 0));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule